// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Read Latency

This block is a true dual-port static memory of 9-bit words. Each of its two ports has its own clock, reset, chip enable, read/write select, output enable, address and data buses. Either port can read or write any word in any cycle, while the other port does the same, and both ports may touch the same word. The array is sized by a parameter: `ADDR_W = 13` gives 8192 words, and one more address bit gives the 16K-word variant. Nothing else changes between sizes.

A per-port mode pin sets the read latency for that port. In flow-through mode the read word appears in the cycle after its address is captured. In pipelined mode one more output register is added, so the word appears one cycle later. The data bus never goes high impedance. Instead each port drives a valid flag, which is low whenever the port is deselected, is writing, or has its output enable low.

Each port writes only its own storage bank. A small table with one bit per word records which port last wrote each location. This keeps every storage element driven from a single clock. A write at a port's clock edge is visible to a read that the other port captures at the same or a later edge.

Top module: `dpram_dual`

## Requirements
- R1: A word written through a port at address X is returned by a later read of X through the same port, at every address.
- R2: In flow-through mode (mode pin 0), a read captured at clock edge k drives valid data from edge k until edge k+1.
- R3: In pipelined mode (mode pin 1), a read captured at edge k drives valid data from edge k+1 until edge k+2. The data is the word the flow-through stage showed in the cycle before.
- R4: With chip enable low, a port neither writes nor reads. The next cycle shows the valid flag low, and memory contents are unchanged.
- R5: With output enable low, the valid flag is low in that same cycle. Reads are still performed and reappear when output enable returns high.
- R6: A write cycle (chip enable high, read/write low) produces no valid read output for that port.
- R7: When one port writes X at the same clock edge at which the other port captures a read of X, the reading port returns the new word.
- R8: A word written by one port is returned by a later read through the other port.
- R9: After reset, both valid flags are low.
- R10: Simultaneous reads and writes on both ports at different addresses all complete correctly, in both latency modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous active-low reset |
| ce_a | input | 1 | Port A chip enable |
| rw_a | input | 1 | Port A access type: 1 read, 0 write |
| oe_a | input | 1 | Port A output enable |
| pipe_a | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A read data |
| dvld_a | output | 1 | Port A read data valid |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous active-low reset |
| ce_b | input | 1 | Port B chip enable |
| rw_b | input | 1 | Port B access type: 1 read, 0 write |
| oe_b | input | 1 | Port B output enable |
| pipe_b | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B read data |
| dvld_b | output | 1 | Port B read data valid |

## Verification
The bench builds the block with `ADDR_W = 4` and `DATA_W = 9`. With only 16 words, every location can be written and read back from each port in a short run. The small space also makes random two-port traffic land on the same address often. That covers the collision between a write on one port and a read on the other, and the ownership bits flip back and forth many times. Both ports share one clock in the bench, so same-edge forwarding can be checked exactly, cycle by cycle, in both latency modes.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] waddr_a,
  input  logic [DATA_W-1:0] wdata_a,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic              clk_b,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] waddr_b,
  input  logic [DATA_W-1:0] wdata_b,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  // one bank per writer; ownership = own_a ^ own_b (0: bank A newest)
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic              own_a  [DEPTH];
  logic              own_b  [DEPTH];

  always_ff @(posedge clk_a) begin
    if (we_a) begin
      bank_a[waddr_a] <= wdata_a;
      own_a[waddr_a]  <= own_b[waddr_a];
    end
  end

  always_ff @(posedge clk_b) begin
    if (we_b) begin
      bank_b[waddr_b] <= wdata_b;
      own_b[waddr_b]  <= ~own_a[waddr_b];
    end
  end

  always_comb begin
    rdata_a = (own_a[raddr_a] ^ own_b[raddr_a]) ? bank_b[raddr_a] : bank_a[raddr_a];
    rdata_b = (own_a[raddr_b] ^ own_b[raddr_b]) ? bank_b[raddr_b] : bank_a[raddr_b];
  end
endmodule

// File: rtl/dpr_port.sv
module dpr_port
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              rw,
  input  logic              oe,
  input  logic              pipe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  logic              rd_req, wr_req;
  lat_mode_e         mode;
  logic              ft_vld_q, ft_vld_d;
  logic [ADDR_W-1:0] ft_addr_q, ft_addr_d;
  logic              pl_vld_q, pl_vld_d;
  logic [DATA_W-1:0] pl_data_q, pl_data_d;
  logic              sel_vld;
  logic [DATA_W-1:0] sel_data;

  assign rd_req    = ce & rw;
  assign wr_req    = ce & ~rw;
  assign mode      = lat_mode_e'(pipe);
  assign mem_we    = wr_req;
  assign mem_waddr = addr;
  assign mem_wdata = din;
  assign mem_raddr = ft_addr_q;

  always_comb begin
    ft_vld_d  = rd_req;
    ft_addr_d = ft_addr_q;
    if (rd_req) ft_addr_d = addr;
    pl_vld_d  = ft_vld_q;
    pl_data_d = pl_data_q;
    if (ft_vld_q) pl_data_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_vld_q <= 1'b0;
      pl_vld_q <= 1'b0;
    end else begin
      ft_vld_q <= ft_vld_d;
      pl_vld_q <= pl_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    ft_addr_q <= ft_addr_d;
    pl_data_q <= pl_data_d;
  end

  always_comb begin
    case (mode)
      LAT_PIPE: begin
        sel_vld  = pl_vld_q;
        sel_data = pl_data_q;
      end
      default: begin
        sel_vld  = ft_vld_q;
        sel_data = mem_rdata;
      end
    endcase
    dout_vld = oe & sel_vld;
    dout     = sel_data;
  end

  // R2
  flow_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !pipe) |=> (pipe || !oe || dout_vld));
  // R3
  pipe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && ft_vld_q) |=> (!pipe || !oe || dout_vld));
  // R3
  pipe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && ft_vld_q) |=> (!pipe || dout == $past(mem_rdata)));
  // R6
  wr_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !pipe) |=> (pipe || !dout_vld));
  // R4
  desel_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !pipe) |=> (pipe || !dout_vld));
endmodule

// File: rtl/dpram_dual.sv
module dpram_dual #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              ce_a,
  input  logic              rw_a,
  input  logic              oe_a,
  input  logic              pipe_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [DATA_W-1:0] dout_a,
  output logic              dvld_a,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              ce_b,
  input  logic              rw_b,
  input  logic              oe_b,
  input  logic              pipe_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] dout_b,
  output logic              dvld_b
);
  logic              we_a, we_b;
  logic [ADDR_W-1:0] wa_a, wa_b, ra_a, ra_b;
  logic [DATA_W-1:0] wd_a, wd_b, rd_a, rd_b;

  dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
    .clk(clk_a), .rst_n(rst_a_n), .ce(ce_a), .rw(rw_a), .oe(oe_a),
    .pipe(pipe_a), .addr(addr_a), .din(din_a), .mem_rdata(rd_a),
    .mem_we(we_a), .mem_waddr(wa_a), .mem_wdata(wd_a), .mem_raddr(ra_a),
    .dout(dout_a), .dout_vld(dvld_a));

  dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
    .clk(clk_b), .rst_n(rst_b_n), .ce(ce_b), .rw(rw_b), .oe(oe_b),
    .pipe(pipe_b), .addr(addr_b), .din(din_b), .mem_rdata(rd_b),
    .mem_we(we_b), .mem_waddr(wa_b), .mem_wdata(wd_b), .mem_raddr(ra_b),
    .dout(dout_b), .dout_vld(dvld_b));

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_a(clk_a), .we_a(we_a), .waddr_a(wa_a), .wdata_a(wd_a),
    .raddr_a(ra_a), .rdata_a(rd_a),
    .clk_b(clk_b), .we_b(we_b), .waddr_b(wa_b), .wdata_b(wd_b),
    .raddr_b(ra_b), .rdata_b(rd_b));
endmodule

// File: tb/dpram_dual_tb.sv
module dpram_dual_tb;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ce [2], rw [2], oe [2], pm [2];
  logic [AW-1:0] ad [2];
  logic [DW-1:0] di [2];
  logic [DW-1:0] dout_a, dout_b;
  logic          dvld_a, dvld_b;

  dpram_dual #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_a(clk), .rst_a_n(rst_n), .ce_a(ce[0]), .rw_a(rw[0]), .oe_a(oe[0]),
    .pipe_a(pm[0]), .addr_a(ad[0]), .din_a(di[0]), .dout_a(dout_a), .dvld_a(dvld_a),
    .clk_b(clk), .rst_b_n(rst_n), .ce_b(ce[1]), .rw_b(rw[1]), .oe_b(oe[1]),
    .pipe_b(pm[1]), .addr_b(ad[1]), .din_b(di[1]), .dout_b(dout_b), .dvld_b(dvld_b));

  // behavioural reference
  int mem [N];
  bit rdq [2];
  int aq [2];
  bit pv [2];
  int pd [2];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin rdq[p] = 0; pv[p] = 0; end
    end else begin
      for (int p = 0; p < 2; p++) begin pv[p] = rdq[p]; pd[p] = mem[aq[p]]; end
      for (int p = 0; p < 2; p++) if (ce[p] && !rw[p]) mem[ad[p]] = int'(di[p]);
      for (int p = 0; p < 2; p++) begin
        rdq[p] = ce[p] && rw[p];
        if (ce[p] && rw[p]) aq[p] = int'(ad[p]);
      end
    end
  end

  task automatic chk(int p, string tag);
    bit ev, gv;
    int ed, gd;
    ev = oe[p] && (pm[p] ? pv[p] : rdq[p]);
    ed = pm[p] ? pd[p] : mem[aq[p]];
    gv = (p == 0) ? dvld_a : dvld_b;
    gd = (p == 0) ? int'(dout_a) : int'(dout_b);
    checks++;
    if (gv !== ev || (ev && gd != ed)) begin
      errors++;
      $display("FAIL %s port %0d: vld=%0b exp %0b data=%0h exp %0h", tag, p, gv, ev, gd, ed);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    chk(0, tag);
    chk(1, tag);
  endtask

  task automatic idle();
    for (int p = 0; p < 2; p++) begin ce[p] = 0; rw[p] = 1; oe[p] = 1; end
  endtask

  task automatic acc(int p, bit c, bit r, int a, int d);
    ce[p] = c; rw[p] = r; ad[p] = AW'(a); di[p] = DW'(d);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin pm[p] = 0; ad[p] = '0; di[p] = '0; end
    for (int i = 0; i < N; i++) mem[i] = 0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: valid flags low after reset
    chk(0, "R9"); chk(1, "R9");
    rst_n = 1'b1;
    step("R9");
    // R1 R6: port A writes every word
    for (int i = 0; i < N; i++) begin acc(0, 1, 0, i, 9'h100 ^ (i * 37)); step("R6"); end
    idle(); step("R6");
    // R1 R2: port A reads back, flow-through
    for (int i = 0; i < N; i++) begin acc(0, 1, 1, i, 0); step("R2"); end
    idle(); step("R1");
    // R8: port B reads words written by A
    for (int i = 0; i < N; i++) begin acc(1, 1, 1, N - 1 - i, 0); step("R8"); end
    idle(); step("R8");
    // R3: both ports pipelined
    pm[0] = 1; pm[1] = 1; step("R3");
    for (int i = 0; i < N; i++) begin acc(0, 1, 1, i, 0); acc(1, 1, 1, i ^ 5, 0); step("R3"); end
    idle(); step("R3"); step("R3");
    // R4: deselected writes have no effect
    pm[0] = 0; pm[1] = 0;
    for (int i = 0; i < 4; i++) begin acc(0, 0, 0, i, 9'h0aa); acc(1, 0, 0, i + 4, 9'h055); step("R4"); end
    for (int i = 0; i < 8; i++) begin acc(0, 1, 1, i, 0); step("R4"); end
    idle(); step("R4");
    // R5: output enable gating with ongoing reads
    for (int i = 0; i < 12; i++) begin
      acc(0, 1, 1, i, 0); acc(1, 1, 1, i, 0);
      oe[0] = i[0]; oe[1] = ~i[1]; pm[1] = i[2];
      step("R5");
    end
    idle(); pm[1] = 0; step("R5"); step("R5");
    // R7: same-edge write on one port, read on the other
    for (int m = 0; m < 2; m++) begin
      pm[0] = m[0]; pm[1] = m[0];
      for (int i = 0; i < 6; i++) begin
        acc(0, 1, 0, i, 9'h1f0 + i + m * 8); acc(1, 1, 1, i, 0); step("R7");
        acc(1, 1, 0, i + 8, 9'h0e0 + i + m * 8); acc(0, 1, 1, i + 8, 0); step("R7");
      end
      idle(); step("R7"); step("R7");
    end
    // R10: random traffic on both ports
    for (int i = 0; i < 400; i++) begin
      int a0, a1;
      a0 = $urandom_range(N - 1);
      a1 = $urandom_range(N - 1);
      acc(0, $urandom_range(3) != 0, $urandom_range(1) == 1, a0, $urandom_range(511));
      acc(1, $urandom_range(3) != 0, $urandom_range(1) == 1, a1, $urandom_range(511));
      if (ce[0] && ce[1] && !rw[0] && !rw[1] && a0 == a1) ce[1] = 0;
      oe[0] = $urandom_range(7) != 0; oe[1] = $urandom_range(7) != 0;
      if (i % 50 == 0) begin pm[0] = $urandom_range(1) == 1; pm[1] = $urandom_range(1) == 1; end
      step("R10");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule